// File: doc/BRIEF.md
# Slave FIFO Streaming Read Controller

This block sits on the FPGA side of a synchronous slave FIFO link to a USB bridge. It moves host-to-device (OUT) data from the bridge's buffers into a local sink. It watches two flags from the bridge. One is a buffer-ready flag, which is 1 while the selected buffer holds data. The other is an active-low partial flag, which marks that the buffer has almost run out. The block drives the active-low chip select, output enable and read strobe. The write strobe and packet-end outputs are held inactive (high) at all times.

The bridge puts a word on the bus two cycles after it sees the read strobe. The block therefore delays a copy of its own strobe and captures the bus only when that delayed copy is set. Each captured word is shown for one cycle on `out_valid_o` / `out_data_o`. A burst does not end on the ready flag. It ends on a countdown that starts when the partial flag is seen asserted on a strobe cycle: `REMAIN = WATERMARK*(32/DATA_W) - 1`.

- Output enable stays asserted for `REMAIN` more cycles.
- The strobe stays asserted for `REMAIN-2` of those cycles.

The bridge's buffer is then fully read, and its ready flag falls.

The states are:

- **IDLE**: all controls are inactive. The block waits for ready = 1.
- **WAIT_FLAG**: chip select and output enable are asserted, no strobe. The block waits for the sink.
- **READ**: the block strobes each cycle that the sink is ready.
- **DRAIN**: the countdown runs.
- **DONE**: a single release cycle.

The transitions are:

- IDLE→WAIT_FLAG when ready = 1.
- WAIT_FLAG→READ when the sink is ready.
- READ→DRAIN when the partial flag is low on a strobe cycle.
- DRAIN→DONE when the count reaches 1.
- DONE→IDLE always.

Top module: `slfifo_stream_rd`

## Requirements
- R1: While `rst_n` is low, `cs_n_o`, `oe_n_o` and `rd_n_o` are 1 and `out_valid_o` is 0.
- R2: `wr_n_o` and `pktend_n_o` are 1 on every cycle.
- R3: A burst starts (`cs_n_o` falls) only after `buf_ready_i` was sampled 1 in IDLE. `rd_n_o` is never 0 unless `cs_n_o` and `oe_n_o` are both 0.
- R4: A strobe in cycle k is answered by the bridge's bus value in cycle k+2. That value appears on `out_data_o` with `out_valid_o`=1 in cycle k+3. `out_valid_o` is 1 only for strobed words, and the output word sequence equals the bridge's word sequence.
- R5: When `part_n_i` is sampled 0 on a READ strobe cycle, `oe_n_o` stays 0 for exactly REMAIN further cycles and `rd_n_o` stays 0 for exactly REMAIN-2 of them. REMAIN = WATERMARK*(32/DATA_W)-1, which is 5 for the defaults (WATERMARK=6, DATA_W=32).
- R6: In READ, a cycle with `sink_ready_i`=0 issues no strobe. Strobing resumes in the first cycle in which `sink_ready_i` is 1.
- R7: In DRAIN, `sink_ready_i` has no effect: the countdown and its strobes complete.
- R8: DONE lasts one cycle with all controls inactive and then goes to IDLE. While `buf_ready_i` is 0, the block stays in IDLE with `cs_n_o`=1.
- R9: A low `part_n_i` sampled in a READ stall cycle (no strobe) does not start DRAIN. Every buffer of at least REMAIN-1 words is read completely, with no read past its end, so the ready flag returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Active-low synchronous reset |
| buf_ready_i | input | 1 | 1 while the selected bridge buffer holds data |
| part_n_i | input | 1 | Active-low partial (watermark) flag |
| fifo_data_i | input | DATA_W | Data bus from the bridge |
| cs_n_o | output | 1 | Active-low chip select |
| oe_n_o | output | 1 | Active-low output enable |
| rd_n_o | output | 1 | Active-low read strobe |
| wr_n_o | output | 1 | Active-low write strobe, held high |
| pktend_n_o | output | 1 | Active-low packet end, held high |
| sink_ready_i | input | 1 | Sink can take more words |
| out_valid_o | output | 1 | Captured word valid |
| out_data_o | output | DATA_W | Captured word |

## Verification
The bound checker covers the cycle-level rules on every cycle:

- The inactive write and packet-end pins.
- No strobe without enable and select.
- No strobe in a stalled READ cycle.
- The three-cycle tie between a valid output and its strobe.
- The one-cycle DONE followed by IDLE.
- The release of output enable after the countdown.

Other properties depend on a bridge holding real buffer contents and flag timing, so only the bench's scenarios can show them:

- The exact lengths of enable and strobe after the partial flag.
- Word order and integrity.
- Complete draining of buffers, including the minimum size.
- Partial-flag sampling during stalls.
- Insensitivity to back-pressure in DRAIN.

// File: rtl/slfifo_rd_pkg.sv
package slfifo_rd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_WAIT_FLAG = 3'd1,
        ST_READ      = 3'd2,
        ST_DRAIN     = 3'd3,
        ST_DONE      = 3'd4
    } rd_state_t;

endpackage

// File: rtl/slfifo_rd_fsm.sv
module slfifo_rd_fsm
    import slfifo_rd_pkg::*;
#(
    parameter int REMAIN = 5,
    parameter int CNT_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             buf_ready_i,
    input  logic             part_n_i,
    input  logic             sink_ready_i,
    output logic             cs_n_o,
    output logic             oe_n_o,
    output logic             rd_n_o,
    output rd_state_t        state_o,
    output logic [CNT_W-1:0] cnt_o
);

    rd_state_t        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             strobe;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (buf_ready_i) state_d = ST_WAIT_FLAG;
            end
            ST_WAIT_FLAG: begin
                if (sink_ready_i) state_d = ST_READ;
            end
            ST_READ: begin
                // partial flag counts only on a cycle that actually strobes
                if (sink_ready_i && !part_n_i) begin
                    state_d = ST_DRAIN;
                    cnt_d   = CNT_W'(REMAIN);
                end
            end
            ST_DRAIN: begin
                cnt_d = cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) state_d = ST_DONE;
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Output logic
    always_comb begin
        cs_n_o = 1'b1;
        oe_n_o = 1'b1;
        strobe = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_DONE: ;
            ST_WAIT_FLAG: begin
                cs_n_o = 1'b0;
                oe_n_o = 1'b0;
            end
            ST_READ: begin
                cs_n_o = 1'b0;
                oe_n_o = 1'b0;
                strobe = sink_ready_i;
            end
            ST_DRAIN: begin
                cs_n_o = 1'b0;
                oe_n_o = 1'b0;
                strobe = (cnt_q > CNT_W'(2));
            end
            default: ;
        endcase
        rd_n_o = ~strobe;
    end

    assign state_o = state_q;
    assign cnt_o   = cnt_q;

endmodule

// File: rtl/slfifo_rd_capture.sv
module slfifo_rd_capture #(
    parameter int DATA_W = 32,
    parameter int LAT    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_n_i,
    input  logic [DATA_W-1:0] bus_i,
    output logic              valid_o,
    output logic [DATA_W-1:0] data_o
);

    logic [LAT:0] strobe_pipe;

    assign strobe_pipe[0] = ~rd_n_i;

    // one flop per cycle of bridge read latency
    for (genvar g = 1; g <= LAT; g++) begin : g_lat
        always_ff @(posedge clk) begin
            if (!rst_n) strobe_pipe[g] <= 1'b0;
            else        strobe_pipe[g] <= strobe_pipe[g-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            data_o  <= '0;
        end else begin
            valid_o <= strobe_pipe[LAT];
            if (strobe_pipe[LAT]) data_o <= bus_i;
        end
    end

endmodule

// File: rtl/slfifo_stream_rd.sv
module slfifo_stream_rd
    import slfifo_rd_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int WATERMARK = 6,
    parameter int RD_LAT    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              buf_ready_i,
    input  logic              part_n_i,
    input  logic [DATA_W-1:0] fifo_data_i,
    output logic              cs_n_o,
    output logic              oe_n_o,
    output logic              rd_n_o,
    output logic              wr_n_o,
    output logic              pktend_n_o,
    input  logic              sink_ready_i,
    output logic              out_valid_o,
    output logic [DATA_W-1:0] out_data_o
);

    localparam int WORDS_PER_UNIT = 32 / DATA_W;
    localparam int REMAIN         = WATERMARK * WORDS_PER_UNIT - 1;
    localparam int CNT_W          = $clog2(REMAIN + 1);

    rd_state_t        fsm_state;
    logic [CNT_W-1:0] drain_cnt;

    slfifo_rd_fsm #(
        .REMAIN (REMAIN),
        .CNT_W  (CNT_W)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .buf_ready_i  (buf_ready_i),
        .part_n_i     (part_n_i),
        .sink_ready_i (sink_ready_i),
        .cs_n_o       (cs_n_o),
        .oe_n_o       (oe_n_o),
        .rd_n_o       (rd_n_o),
        .state_o      (fsm_state),
        .cnt_o        (drain_cnt)
    );

    slfifo_rd_capture #(
        .DATA_W (DATA_W),
        .LAT    (RD_LAT)
    ) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_n_i  (rd_n_o),
        .bus_i   (fifo_data_i),
        .valid_o (out_valid_o),
        .data_o  (out_data_o)
    );

    assign wr_n_o     = 1'b1;
    assign pktend_n_o = 1'b1;

endmodule

// File: rtl/slfifo_rd_chk.sv
module slfifo_rd_chk
    import slfifo_rd_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input rd_state_t        state,
    input logic [CNT_W-1:0] cnt,
    input logic             buf_ready_i,
    input logic             sink_ready_i,
    input logic             cs_n_o,
    input logic             oe_n_o,
    input logic             rd_n_o,
    input logic             wr_n_o,
    input logic             pktend_n_o,
    input logic             out_valid_o
);

    assert_write_side_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_n_o && pktend_n_o);

    assert_strobe_needs_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n_o |-> (!oe_n_o && !cs_n_o));

    assert_idle_waits_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !buf_ready_i) |=> cs_n_o);

    assert_valid_lags_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> $past(!rd_n_o, 3));

    assert_drain_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRAIN && cnt == CNT_W'(1)) |=> oe_n_o);

    assert_stall_no_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READ && !sink_ready_i) |-> rd_n_o);

    assert_done_to_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE) |=> (state == ST_IDLE));

endmodule

bind slfifo_stream_rd slfifo_rd_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .state        (fsm_state),
    .cnt          (drain_cnt),
    .buf_ready_i  (buf_ready_i),
    .sink_ready_i (sink_ready_i),
    .cs_n_o       (cs_n_o),
    .oe_n_o       (oe_n_o),
    .rd_n_o       (rd_n_o),
    .wr_n_o       (wr_n_o),
    .pktend_n_o   (pktend_n_o),
    .out_valid_o  (out_valid_o)
);

// File: tb/tb_slfifo_stream_rd.sv
module tb_slfifo_stream_rd;

    localparam int DW     = 32;
    localparam int WM     = 6;
    localparam int REMAIN = WM * (32 / DW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          buf_ready, part_n, sink_ready;
    logic [DW-1:0] bus;
    logic          cs_n, oe_n, rd_n, wr_n, pktend_n, out_valid;
    logic [DW-1:0] out_data;

    always #5 clk = ~clk;

    slfifo_stream_rd #(.DATA_W(DW), .WATERMARK(WM)) dut (
        .clk(clk), .rst_n(rst_n), .buf_ready_i(buf_ready), .part_n_i(part_n),
        .fifo_data_i(bus), .cs_n_o(cs_n), .oe_n_o(oe_n), .rd_n_o(rd_n),
        .wr_n_o(wr_n), .pktend_n_o(pktend_n), .sink_ready_i(sink_ready),
        .out_valid_o(out_valid), .out_data_o(out_data)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] word_of(input int id, input int idx);
        return {8'hC3, id[7:0], idx[15:0]};
    endfunction

    // ---------------- bridge model ----------------
    int   left = 0, rd_idx = 0, bid = 0, cyc = 0;
    int   req_seq = 0, ack_seq = 0, load_size = 0, load_id = 0;
    logic s1 = 1'b0;
    logic [DW-1:0] w1 = '0;
    bit   in_drain = 1'b0;
    int   oe_cnt = 0, rdc = 0, last_oe = 0, last_rd = 0, drain_seq = 0;
    int   bp_viol = 0, r3_viol = 0, r2_viol = 0, over_read = 0;
    logic cs_prev = 1'b1, rdy_prev = 1'b0;

    assign buf_ready = (left != 0);
    assign part_n    = !(left <= REMAIN - 1);

    always @(posedge clk) begin
        bit fire;
        fire = !cs_n && !oe_n && !rd_n;
        cyc <= cyc + 1;
        s1  <= fire && (left > 0);
        bus <= s1 ? w1 : (32'hBAD0_0000 | DW'(cyc[15:0]));
        if (fire) begin
            if (left == 0) over_read <= over_read + 1;
            else begin
                w1     <= word_of(bid, rd_idx);
                rd_idx <= rd_idx + 1;
                left   <= left - 1;
            end
        end else if (req_seq != ack_seq && left == 0) begin
            left    <= load_size;
            bid     <= load_id;
            rd_idx  <= 0;
            ack_seq <= req_seq;
        end
        // drain measurement (R5)
        if (!in_drain && fire && !part_n) begin
            in_drain <= 1'b1;
            oe_cnt   <= 0;
            rdc      <= 0;
        end else if (in_drain) begin
            if (oe_n) begin
                in_drain  <= 1'b0;
                last_oe   <= oe_cnt;
                last_rd   <= rdc;
                drain_seq <= drain_seq + 1;
            end else begin
                oe_cnt <= oe_cnt + 1;
                if (fire) rdc <= rdc + 1;
            end
        end
        if (rst_n) begin
            if (fire && !sink_ready && !in_drain) bp_viol <= bp_viol + 1;   // R6
            if (!rd_n && (oe_n || cs_n)) r3_viol <= r3_viol + 1;            // R3
            if (!cs_n && cs_prev && !rdy_prev) r3_viol <= r3_viol + 1;      // R3
            if (!wr_n || !pktend_n) r2_viol <= r2_viol + 1;                 // R2
        end
        cs_prev  <= cs_n;
        rdy_prev <= buf_ready;
    end

    // ---------------- sink ----------------
    int mode = 0, cur_id = 0, base = 0, rx_total = 0;

    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            chk(out_data == word_of(cur_id, rx_total - base), "R4 word",
                out_data, word_of(cur_id, rx_total - base));
            rx_total <= rx_total + 1;
        end
    end

    initial begin
        sink_ready = 1'b1;
        forever begin
            @(negedge clk);
            case (mode)
                1:       sink_ready = ($urandom_range(0, 99) < 60);
                2:       sink_ready = !in_drain;
                default: sink_ready = 1'b1;
            endcase
        end
    end

    task automatic run_burst(input int size, input int m, input int id);
        int d0, bp0, r30, r20;
        mode = m; cur_id = id; base = rx_total;
        d0 = drain_seq; bp0 = bp_viol; r30 = r3_viol; r20 = r2_viol;
        load_size = size; load_id = id;
        req_seq++;
        while (!(drain_seq != d0 && rx_total - base == size)) @(negedge clk);
        repeat (4) @(negedge clk);
        chk(rx_total - base == size, "R4 count", rx_total - base, size);
        chk(last_oe == REMAIN, "R5 oe", last_oe, REMAIN);
        chk(last_rd == REMAIN - 2, "R5 rd", last_rd, REMAIN - 2);
        chk(bp_viol == bp0, "R6 stall strobe", bp_viol - bp0, 0);
        chk(r3_viol == r30, "R3 control order", r3_viol - r30, 0);
        chk(r2_viol == r20, "R2 write side", r2_viol - r20, 0);
        chk(!buf_ready && over_read == 0, "R9 drained", over_read, 0);
        if (m == 2) chk(last_rd == REMAIN - 2, "R7 drain ignores sink", last_rd, REMAIN - 2);
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        chk(cs_n && oe_n && rd_n && !out_valid, "R1 reset", {cs_n, oe_n, rd_n, out_valid}, 4'b1110);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R8: no buffer, stays idle
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (!cs_n) r3_viol++;
        end
        chk(cs_n && r3_viol == 0, "R8 idle hold", cs_n, 1);
        run_burst(REMAIN - 1, 0, 1);   // minimum buffer, flag already low (R9)
        run_burst(REMAIN, 0, 2);
        run_burst(REMAIN + 1, 0, 3);
        run_burst(37, 2, 4);           // sink low through DRAIN (R7)
        for (int b = 0; b < 20; b++)
            run_burst($urandom_range(REMAIN - 1, 64), 1, 10 + b);  // stalls incl. R9 cases
        repeat (10) @(negedge clk);
        chk(cs_n, "R8 idle after bursts", cs_n, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule